// File: doc/BRIEF.md
# Privileged CSR Legalization Unit

This block holds the machine-level control and status registers of a 64-bit hart and legalizes every access to them. It sets each register to a defined value at reset and screens each write against that register's rules. Reads are masked where the architecture asks for it. Reads of the counters are gated by the privilege level of the requester. The surrounding pipeline gives it a register index, read and write strobes, write data, the current privilege, the address of the next instruction, and the free-running cycle, time and retired-instruction counts. It returns read data, an access-denied flag and an unknown-index flag.

Accesses are single-beat control transactions, so the interface uses plain strobes and has no valid/ready pair. The block never back-pressures: one access can be issued every cycle. The response registers update on the clock edge that accepts the strobe. When read and write strobes are both high in the same cycle, the read returns the value held before the write.

Privilege is encoded as 0 user, 1 supervisor, 2 reserved, 3 machine. The indices follow the standard numbering:

| Register | Index |
|---|---|
| status | 0x300 |
| extension word | 0x301 |
| machine counter enable | 0x306 |
| machine exception PC | 0x341 |
| supervisor counter enable | 0x106 |
| supervisor exception PC | 0x141 |
| translation control | 0x180 |
| trigger select | 0x7A0 |
| counters | 0xC00 to 0xC1F |

Among the counters, 0xC00 is cycle, 0xC01 is time and 0xC02 is retired instructions.

Top module: `csr_legal_unit`

## Requirements
- R1: After reset the registers read as follows. The extension word reads 0x800000000014112D (bits 63:62 = 2 and C = bit 2 set). The status register reads 0x0000000A00002000 (bits 35:34 = 2, bits 33:32 = 2, bits 14:13 = 1). Both counter-enable registers read 0x7. Trigger select reads 1. Translation control reads 0.
- R2: Privilege decides whether a counter read is allowed. Machine privilege may always read. Supervisor privilege needs bit n of the machine counter-enable register, and user privilege needs bit n of the supervisor counter-enable register, where n = index - 0xC00. The reserved privilege value is always refused. A refused read returns zero and raises the denied flag.
- R3: The counter at 0xC01 returns the time input and 0xC02 returns the retired-instruction input. The counter at 0xC00 and every counter from 0xC03 to 0xC1F return the cycle input.
- R4: A write to any counter index has no effect on any register and raises no flag.
- R5: A read of either exception PC clears bit 0 when the C bit (bit 2) of the extension word is set. It clears bits 1:0 when the C bit is clear. The stored value is kept unmasked.
- R6: A translation-control write keeps its mode field (bits 63:60) only if that field is 0 or 8. For any other mode the previous mode is kept, and bits 59:0 are still written.
- R7: A write to trigger select stores the written value plus one.
- R8: Clearing the C bit of the extension word takes effect only when next-PC bits 2:0 are zero. Otherwise the old C bit is kept and the other bits of the write are applied. Setting C is always accepted.
- R9: Status bits 35:32 never change on a write. Every other bit takes the written value.
- R10: An access to any other index returns zero and raises the unknown-index flag, and a write to it changes no register.
- R11: The read data and both flags are valid in the cycle after the strobe and are zero in a cycle after no strobe. A write is visible to the next access.
- R12: The counter-enable registers are 32 bits wide: upper write bits are dropped and they read zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_rd_en | input | 1 | Read strobe |
| csr_wr_en | input | 1 | Write strobe |
| csr_addr | input | 12 | Register index |
| csr_wdata | input | 64 | Write data |
| cur_priv | input | 2 | Privilege of the requester |
| next_pc | input | 64 | Address of the next instruction |
| cycle_count | input | 64 | Free-running cycle count |
| time_count | input | 64 | Wall-time count |
| instret_count | input | 64 | Retired-instruction count |
| csr_rdata | output | 64 | Read data, registered |
| csr_denied | output | 1 | Counter read refused, registered |
| csr_illegal | output | 1 | Unknown index accessed, registered |

## Verification
Every result of this block is due exactly one clock edge after its strobe. This covers read data, the denied flag and the unknown-index flag. A legalized write is visible to a read issued in the next cycle, so a write followed by a read shows its effect two edges after the write strobe. The bench drives each access at a falling edge and samples one nanosecond after the following rising edge. It drops the strobes at that point, so each sample sees only the response to one access. The same-cycle read and write case is checked at that edge for the old value, and one access later for the new one.

// File: rtl/csr_legal_pkg.sv
package csr_legal_pkg;
  localparam int XLEN    = 64;
  localparam int ADDR_W  = 12;
  localparam int NUM_CTR = 32;
  localparam int CEN_W   = NUM_CTR;
  localparam int CTR_SEL_W = $clog2(NUM_CTR);

  typedef logic [ADDR_W-1:0] csr_addr_t;
  typedef logic [XLEN-1:0]   word_t;

  // privilege encodings
  localparam logic [1:0] PRIV_USER  = 2'd0;
  localparam logic [1:0] PRIV_SUPER = 2'd1;
  localparam logic [1:0] PRIV_MACH  = 2'd3;

  // register indices
  localparam csr_addr_t IX_STATUS   = 12'h300;
  localparam csr_addr_t IX_EXTWORD  = 12'h301;
  localparam csr_addr_t IX_MCEN     = 12'h306;
  localparam csr_addr_t IX_MEPC     = 12'h341;
  localparam csr_addr_t IX_SCEN     = 12'h106;
  localparam csr_addr_t IX_SEPC     = 12'h141;
  localparam csr_addr_t IX_XLATE    = 12'h180;
  localparam csr_addr_t IX_TRIGSEL  = 12'h7A0;
  localparam csr_addr_t IX_CTR_BASE = 12'hC00;

  // field positions
  localparam int C_BIT    = 2;
  localparam int XL_LO    = 32;
  localparam int XL_HI    = 35;
  localparam int MODE_LO  = 60;
  localparam int MODE_HI  = 63;
  localparam int PC_AL_W  = 3;

  localparam logic [3:0] MODE_BARE = 4'd0;
  localparam logic [3:0] MODE_PG39 = 4'd8;

  localparam word_t          EXTWORD_RESET = 64'h8000_0000_0014_112D;
  localparam word_t          STATUS_RESET  = 64'h0000_000A_0000_2000;
  localparam logic [CEN_W-1:0] CEN_RESET   = 32'h0000_0007;
  localparam word_t          TRIGSEL_RESET = 64'd1;

  typedef struct packed {
    word_t             extword;
    word_t             status;
    word_t             mepc;
    word_t             sepc;
    word_t             xlate;
    word_t             trigsel;
    logic [CEN_W-1:0]  mcen;
    logic [CEN_W-1:0]  scen;
  } csr_state_t;

  localparam csr_state_t STATE_RESET = '{
    extword: EXTWORD_RESET,
    status:  STATUS_RESET,
    mepc:    '0,
    sepc:    '0,
    xlate:   '0,
    trigsel: TRIGSEL_RESET,
    mcen:    CEN_RESET,
    scen:    CEN_RESET
  };

  function automatic logic mode_supported(input logic [3:0] m);
    return (m == MODE_BARE) || (m == MODE_PG39);
  endfunction

  function automatic word_t epc_view(input word_t raw, input logic c_on);
    word_t v;
    v = raw;
    v[0] = 1'b0;
    if (!c_on) v[1] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/csr_counter_gate.sv
module csr_counter_gate
  import csr_legal_pkg::*;
#(
  parameter int N_CTR = NUM_CTR
) (
  input  csr_addr_t        addr,
  input  logic [1:0]       priv,
  input  logic [CEN_W-1:0] mcen,
  input  logic [CEN_W-1:0] scen,
  input  word_t            cycle_cnt,
  input  word_t            time_cnt,
  input  word_t            instret_cnt,
  output logic             is_ctr,
  output logic             deny,
  output word_t            value
);
  localparam int SEL_W = $clog2(N_CTR);

  logic [SEL_W-1:0] sel;
  logic             permit;
  word_t            src [N_CTR];

  // every slot but time and retired-instruction mirrors the cycle count
  for (genvar g = 0; g < N_CTR; g++) begin : g_src
    if (g == 1) begin : g_time
      assign src[g] = time_cnt;
    end else if (g == 2) begin : g_inst
      assign src[g] = instret_cnt;
    end else begin : g_cyc
      assign src[g] = cycle_cnt;
    end
  end

  assign sel    = addr[SEL_W-1:0];
  assign is_ctr = (addr[ADDR_W-1:SEL_W] == IX_CTR_BASE[ADDR_W-1:SEL_W]);

  always_comb begin
    case (priv)
      PRIV_MACH:  permit = 1'b1;
      PRIV_SUPER: permit = mcen[sel];
      PRIV_USER:  permit = scen[sel];
      default:    permit = 1'b0;
    endcase
  end

  assign deny  = is_ctr && !permit;
  assign value = (is_ctr && permit) ? src[sel] : '0;
endmodule

// File: rtl/csr_state_regs.sv
module csr_state_regs
  import csr_legal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  csr_addr_t  addr,
  input  word_t      wdata,
  input  word_t      next_pc,
  input  logic       addr_known,
  input  logic       addr_is_ctr,
  output csr_state_t st
);
  csr_state_t st_q, st_d;
  logic       pc_aligned;
  logic       unused_pc_hi;

  assign pc_aligned   = (next_pc[PC_AL_W-1:0] == '0);
  assign unused_pc_hi = ^next_pc[XLEN-1:PC_AL_W];

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      case (addr)
        IX_EXTWORD: begin
          st_d.extword = wdata;
          if (!wdata[C_BIT] && !pc_aligned)
            st_d.extword[C_BIT] = st_q.extword[C_BIT];
        end
        IX_STATUS: begin
          st_d.status = wdata;
          st_d.status[XL_HI:XL_LO] = st_q.status[XL_HI:XL_LO];
        end
        IX_MEPC:    st_d.mepc = wdata;
        IX_SEPC:    st_d.sepc = wdata;
        IX_XLATE: begin
          st_d.xlate = wdata;
          if (!mode_supported(wdata[MODE_HI:MODE_LO]))
            st_d.xlate[MODE_HI:MODE_LO] = st_q.xlate[MODE_HI:MODE_LO];
        end
        IX_TRIGSEL: st_d.trigsel = wdata + word_t'(1);
        IX_MCEN:    st_d.mcen = wdata[CEN_W-1:0];
        IX_SCEN:    st_d.scen = wdata[CEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= STATE_RESET;
    else        st_q <= st_d;
  end

  assign st = st_q;

  // R6: an unsupported mode leaves the stored mode untouched
  assert_xlate_mode_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == IX_XLATE && !mode_supported(wdata[MODE_HI:MODE_LO])
    |=> st_q.xlate[MODE_HI:MODE_LO] == $past(st_q.xlate[MODE_HI:MODE_LO]));

  assert_xlate_mode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == IX_XLATE |=> mode_supported(st_q.xlate[MODE_HI:MODE_LO]));

  assert_trigsel_incr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == IX_TRIGSEL |=> st_q.trigsel == $past(wdata) + 64'd1);

  assert_c_bit_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == IX_EXTWORD && !wdata[C_BIT] && next_pc[PC_AL_W-1:0] != '0
    |=> st_q.extword[C_BIT] == $past(st_q.extword[C_BIT]));

  assert_status_xl_pinned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(st_q.status[XL_HI:XL_LO]));

  // R4 and R10: counter writes and unknown-index writes leave every register as it was
  assert_ignored_write_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr_is_ctr || !addr_known) |=> $stable(st_q));
endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
  import csr_legal_pkg::*;
(
  input  csr_addr_t  addr,
  input  csr_state_t st,
  input  logic       ctr_hit,
  input  word_t      ctr_value,
  output logic       known,
  output word_t      value
);
  localparam int PAD_W = XLEN - CEN_W;

  always_comb begin
    known = 1'b1;
    value = '0;
    case (addr)
      IX_EXTWORD: value = st.extword;
      IX_STATUS:  value = st.status;
      IX_MEPC:    value = epc_view(st.mepc, st.extword[C_BIT]);
      IX_SEPC:    value = epc_view(st.sepc, st.extword[C_BIT]);
      IX_XLATE:   value = st.xlate;
      IX_TRIGSEL: value = st.trigsel;
      IX_MCEN:    value = {{PAD_W{1'b0}}, st.mcen};
      IX_SCEN:    value = {{PAD_W{1'b0}}, st.scen};
      default: begin
        known = ctr_hit;
        value = ctr_value;
      end
    endcase
  end
endmodule

// File: rtl/csr_legal_unit.sv
module csr_legal_unit
  import csr_legal_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_rd_en,
  input  logic        csr_wr_en,
  input  logic [11:0] csr_addr,
  input  logic [63:0] csr_wdata,
  input  logic [1:0]  cur_priv,
  input  logic [63:0] next_pc,
  input  logic [63:0] cycle_count,
  input  logic [63:0] time_count,
  input  logic [63:0] instret_count,
  output logic [63:0] csr_rdata,
  output logic        csr_denied,
  output logic        csr_illegal
);
  csr_state_t st;
  logic       ctr_hit, ctr_deny, known;
  word_t      ctr_value, rd_value;
  word_t      rdata_q;
  logic       denied_q, illegal_q;

  csr_counter_gate u_gate (
    .addr        (csr_addr),
    .priv        (cur_priv),
    .mcen        (st.mcen),
    .scen        (st.scen),
    .cycle_cnt   (cycle_count),
    .time_cnt    (time_count),
    .instret_cnt (instret_count),
    .is_ctr      (ctr_hit),
    .deny        (ctr_deny),
    .value       (ctr_value)
  );

  csr_read_mux u_mux (
    .addr      (csr_addr),
    .st        (st),
    .ctr_hit   (ctr_hit),
    .ctr_value (ctr_value),
    .known     (known),
    .value     (rd_value)
  );

  csr_state_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (csr_wr_en),
    .addr        (csr_addr),
    .wdata       (csr_wdata),
    .next_pc     (next_pc),
    .addr_known  (known),
    .addr_is_ctr (ctr_hit),
    .st          (st)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q   <= '0;
      denied_q  <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      rdata_q   <= csr_rd_en ? rd_value : '0;
      denied_q  <= csr_rd_en && ctr_deny;
      illegal_q <= (csr_rd_en || csr_wr_en) && !known;
    end
  end

  assign csr_rdata   = rdata_q;
  assign csr_denied  = denied_q;
  assign csr_illegal = illegal_q;

  assert_mach_never_denied_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd_en && cur_priv == PRIV_MACH |=> !csr_denied);

  assert_denied_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_denied |-> csr_rdata == '0);

  assert_unknown_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> csr_rdata == '0 && !csr_denied);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rd_en && !csr_wr_en |=> csr_rdata == '0 && !csr_denied && !csr_illegal);
endmodule

// File: tb/csr_legal_unit_test.sv
module csr_legal_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [1:0]  priv = 2'd3;
  logic [63:0] npc = 64'h1000;
  logic [63:0] cyc = 64'h1111, tim = 64'h2222, ins = 64'h3333;
  logic [63:0] rdata;
  logic        denied, illegal;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  csr_legal_unit uut (
    .clk(clk), .rst_n(rst_n), .csr_rd_en(rd_en), .csr_wr_en(wr_en),
    .csr_addr(addr), .csr_wdata(wdata), .cur_priv(priv), .next_pc(npc),
    .cycle_count(cyc), .time_count(tim), .instret_count(ins),
    .csr_rdata(rdata), .csr_denied(denied), .csr_illegal(illegal)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  pv;
    logic [11:0] ix;
    logic [2:0]  pc;
    logic [63:0] wd;
    logic [63:0] exp;
    logic        den;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 60;
  localparam vec_t VT [NV] = '{
    // R1 reset values
    '{1'b0, 2'd3, 12'h301, 3'd0, 64'h0, 64'h8000000000141_12D, 1'b0, 1'b0, 4'd1},
    '{1'b0, 2'd3, 12'h300, 3'd0, 64'h0, 64'h0000000A00002000, 1'b0, 1'b0, 4'd1},
    '{1'b0, 2'd3, 12'h306, 3'd0, 64'h0, 64'h7, 1'b0, 1'b0, 4'd1},
    '{1'b0, 2'd3, 12'h106, 3'd0, 64'h0, 64'h7, 1'b0, 1'b0, 4'd1},
    '{1'b0, 2'd3, 12'h7A0, 3'd0, 64'h0, 64'h1, 1'b0, 1'b0, 4'd1},
    '{1'b0, 2'd3, 12'h180, 3'd0, 64'h0, 64'h0, 1'b0, 1'b0, 4'd1},
    // R3 cycle
    '{1'b0, 2'd3, 12'hC00, 3'd0, 64'h0, 64'h1111, 1'b0, 1'b0, 4'd3},
    // R7 trigger select
    '{1'b1, 2'd3, 12'h7A0, 3'd0, 64'h5, 64'h0, 1'b0, 1'b0, 4'd7},
    '{1'b0, 2'd3, 12'h7A0, 3'd0, 64'h0, 64'h6, 1'b0, 1'b0, 4'd7},
    // R6 translation mode
    '{1'b1, 2'd3, 12'h180, 3'd0, 64'h8000000000001234, 64'h0, 1'b0, 1'b0, 4'd6},
    '{1'b0, 2'd3, 12'h180, 3'd0, 64'h0, 64'h8000000000001234, 1'b0, 1'b0, 4'd6},
    '{1'b1, 2'd3, 12'h180, 3'd0, 64'h5000000000000ABC, 64'h0, 1'b0, 1'b0, 4'd6},
    '{1'b0, 2'd3, 12'h180, 3'd0, 64'h0, 64'h8000000000000ABC, 1'b0, 1'b0, 4'd6},
    '{1'b1, 2'd3, 12'h180, 3'd0, 64'h77, 64'h0, 1'b0, 1'b0, 4'd6},
    '{1'b0, 2'd3, 12'h180, 3'd0, 64'h0, 64'h77, 1'b0, 1'b0, 4'd6},
    // R9 status pinning
    '{1'b1, 2'd3, 12'h300, 3'd0, 64'hFFFFFFFFFFFFFFFF, 64'h0, 1'b0, 1'b0, 4'd9},
    '{1'b0, 2'd3, 12'h300, 3'd0, 64'h0, 64'hFFFFFFFAFFFFFFFF, 1'b0, 1'b0, 4'd9},
    '{1'b1, 2'd3, 12'h300, 3'd0, 64'h0, 64'h0, 1'b0, 1'b0, 4'd9},
    '{1'b0, 2'd3, 12'h300, 3'd0, 64'h0, 64'h0000000A00000000, 1'b0, 1'b0, 4'd9},
    // R5 exception PC masking, C on
    '{1'b1, 2'd3, 12'h341, 3'd0, 64'h1003, 64'h0, 1'b0, 1'b0, 4'd5},
    '{1'b0, 2'd3, 12'h341, 3'd0, 64'h0, 64'h1002, 1'b0, 1'b0, 4'd5},
    '{1'b1, 2'd3, 12'h141, 3'd0, 64'h2007, 64'h0, 1'b0, 1'b0, 4'd5},
    '{1'b0, 2'd3, 12'h141, 3'd0, 64'h0, 64'h2006, 1'b0, 1'b0, 4'd5},
    // R8 C bit rule
    '{1'b1, 2'd3, 12'h301, 3'd6, 64'h8000000000141129, 64'h0, 1'b0, 1'b0, 4'd8},
    '{1'b0, 2'd3, 12'h301, 3'd0, 64'h0, 64'h800000000014112D, 1'b0, 1'b0, 4'd8},
    '{1'b1, 2'd3, 12'h301, 3'd6, 64'h8000000000141128, 64'h0, 1'b0, 1'b0, 4'd8},
    '{1'b0, 2'd3, 12'h301, 3'd0, 64'h0, 64'h800000000014112C, 1'b0, 1'b0, 4'd8},
    '{1'b1, 2'd3, 12'h301, 3'd0, 64'h8000000000141129, 64'h0, 1'b0, 1'b0, 4'd8},
    '{1'b0, 2'd3, 12'h301, 3'd0, 64'h0, 64'h8000000000141129, 1'b0, 1'b0, 4'd8},
    // R5 C off
    '{1'b0, 2'd3, 12'h341, 3'd0, 64'h0, 64'h1000, 1'b0, 1'b0, 4'd5},
    '{1'b0, 2'd3, 12'h141, 3'd0, 64'h0, 64'h2004, 1'b0, 1'b0, 4'd5},
    '{1'b1, 2'd3, 12'h301, 3'd2, 64'h800000000014112D, 64'h0, 1'b0, 1'b0, 4'd8},
    '{1'b0, 2'd3, 12'h301, 3'd0, 64'h0, 64'h800000000014112D, 1'b0, 1'b0, 4'd8},
    '{1'b0, 2'd3, 12'h341, 3'd0, 64'h0, 64'h1002, 1'b0, 1'b0, 4'd5},
    // R2 privilege gating
    '{1'b1, 2'd3, 12'h306, 3'd0, 64'h5, 64'h0, 1'b0, 1'b0, 4'd2},
    '{1'b0, 2'd1, 12'hC00, 3'd0, 64'h0, 64'h1111, 1'b0, 1'b0, 4'd2},
    '{1'b0, 2'd1, 12'hC01, 3'd0, 64'h0, 64'h0, 1'b1, 1'b0, 4'd2},
    '{1'b0, 2'd1, 12'hC02, 3'd0, 64'h0, 64'h3333, 1'b0, 1'b0, 4'd3},
    '{1'b0, 2'd0, 12'hC01, 3'd0, 64'h0, 64'h2222, 1'b0, 1'b0, 4'd2},
    '{1'b1, 2'd3, 12'h106, 3'd0, 64'h0, 64'h0, 1'b0, 1'b0, 4'd2},
    '{1'b0, 2'd0, 12'hC00, 3'd0, 64'h0, 64'h0, 1'b1, 1'b0, 4'd2},
    '{1'b0, 2'd1, 12'hC00, 3'd0, 64'h0, 64'h1111, 1'b0, 1'b0, 4'd2},
    '{1'b0, 2'd3, 12'hC01, 3'd0, 64'h0, 64'h2222, 1'b0, 1'b0, 4'd2},
    // R3 high counters
    '{1'b1, 2'd3, 12'h306, 3'd0, 64'hD, 64'h0, 1'b0, 1'b0, 4'd3},
    '{1'b0, 2'd1, 12'hC03, 3'd0, 64'h0, 64'h1111, 1'b0, 1'b0, 4'd3},
    '{1'b0, 2'd1, 12'hC04, 3'd0, 64'h0, 64'h0, 1'b1, 1'b0, 4'd2},
    '{1'b0, 2'd3, 12'hC1F, 3'd0, 64'h0, 64'h1111, 1'b0, 1'b0, 4'd3},
    // R4 counter writes
    '{1'b1, 2'd3, 12'hC00, 3'd0, 64'hDEAD, 64'h0, 1'b0, 1'b0, 4'd4},
    '{1'b0, 2'd3, 12'hC00, 3'd0, 64'h0, 64'h1111, 1'b0, 1'b0, 4'd4},
    // R12 enable width
    '{1'b1, 2'd3, 12'h306, 3'd0, 64'hFFFFFFFF80000000, 64'h0, 1'b0, 1'b0, 4'd12},
    '{1'b0, 2'd3, 12'h306, 3'd0, 64'h0, 64'h80000000, 1'b0, 1'b0, 4'd12},
    '{1'b0, 2'd1, 12'hC1F, 3'd0, 64'h0, 64'h1111, 1'b0, 1'b0, 4'd3},
    '{1'b0, 2'd1, 12'hC00, 3'd0, 64'h0, 64'h0, 1'b1, 1'b0, 4'd2},
    // R10 unknown index
    '{1'b0, 2'd3, 12'h123, 3'd0, 64'h0, 64'h0, 1'b0, 1'b1, 4'd10},
    '{1'b1, 2'd3, 12'h123, 3'd0, 64'h99, 64'h0, 1'b0, 1'b1, 4'd10},
    '{1'b1, 2'd3, 12'h7A1, 3'd0, 64'hAAAA, 64'h0, 1'b0, 1'b1, 4'd10},
    '{1'b0, 2'd3, 12'h7A0, 3'd0, 64'h0, 64'h6, 1'b0, 1'b0, 4'd10},
    // R2 reserved privilege refused
    '{1'b0, 2'd2, 12'hC00, 3'd0, 64'h0, 64'h0, 1'b1, 1'b0, 4'd2},
    // R4 retired-instruction write ignored
    '{1'b1, 2'd3, 12'hC02, 3'd0, 64'h5, 64'h0, 1'b0, 1'b0, 4'd4},
    '{1'b0, 2'd3, 12'hC02, 3'd0, 64'h0, 64'h3333, 1'b0, 1'b0, 4'd4}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic r, input logic [1:0] p,
                        input logic [11:0] a, input logic [2:0] pc, input logic [63:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; priv = p; addr = a; wdata = d;
    npc = {61'h200, pc};
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 rdata in reset", rdata, 64'h0);
    check("R1 flags in reset", {62'h0, denied, illegal}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VT[i].wr, !VT[i].wr, VT[i].pv, VT[i].ix, VT[i].pc, VT[i].wd);
      check($sformatf("R%0d vec %0d rdata", VT[i].req, i), rdata, VT[i].exp);
      check($sformatf("R%0d vec %0d denied", VT[i].req, i), {63'h0, denied}, {63'h0, VT[i].den});
      check($sformatf("R%0d vec %0d illegal", VT[i].req, i), {63'h0, illegal}, {63'h0, VT[i].ill});
    end

    // R11: idle cycle after a read returns zero
    access(1'b0, 1'b1, 2'd3, 12'h301, 3'd0, 64'h0);
    access(1'b0, 1'b0, 2'd3, 12'h301, 3'd0, 64'h0);
    check("R11 idle rdata", rdata, 64'h0);

    // R11: read and write in one cycle returns the old value, then the new one
    access(1'b1, 1'b1, 2'd3, 12'h7A0, 3'd0, 64'h20);
    check("R11 same-cycle old value", rdata, 64'h6);
    access(1'b0, 1'b1, 2'd3, 12'h7A0, 3'd0, 64'h0);
    check("R11 write visible next", rdata, 64'h21);

    // R1: reset in mid-run restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 1'b1, 2'd3, 12'h7A0, 3'd0, 64'h0);
    check("R1 trigger select after reset", rdata, 64'h1);
    access(1'b0, 1'b1, 2'd3, 12'h180, 3'd0, 64'h0);
    check("R1 translation after reset", rdata, 64'h0);
    access(1'b0, 1'b1, 2'd3, 12'h306, 3'd0, 64'h0);
    check("R1 counter enable after reset", rdata, 64'h7);
    access(1'b0, 1'b1, 2'd0, 12'hC01, 3'd0, 64'h0);
    check("R2 user time after reset", rdata, 64'h2222);

    finish_run();
  end
endmodule